// File: doc/BRIEF.md
# Biphase-Mark Multiplex Frame Receiver

This block takes a serial line carrying 512-bit multiplex frames in biphase-mark coding and turns each frame back into its header fields and sixteen 28-bit channel words. The line is sampled once per clock, and the clock runs at a fixed multiple `OVS` of the half-cell rate. The receiver measures the time between line transitions and sorts each interval by length. A half-cell interval, a full-bit interval and a two-bit sync run are the legal kinds. Bits are recovered only from the presence or absence of a mid-cell transition, so an inverted line decodes the same as a normal one.

Each frame begins with a code violation: two back-to-back runs of two bit periods each with no transition. This is longer than any legal data interval. Once that pattern is found, the next 508 decoded bits are collected as frame bits 4 to 511. At the end of the frame the header is split into its fields, and both header parity spans are checked. The frame is then offered on a valid/ready output together with all its channel words. A supervisor declares lock when sync patterns arrive one frame apart, and it drops lock when two expected syncs in a row fail to appear.

Output back-pressure rules: a frame stays on the outputs, unchanged, with `o_valid` high, until a cycle with `o_ready` high takes it. The line cannot be stalled. A frame that completes while the previous one is still waiting is discarded. A completed frame is loaded in the same cycle that the waiting one is taken.

Top module: `bmc_frame_rx`

## Requirements
- R1: Decoded frames are identical whether `rx_line` carries the signal or its inverse; no output depends on the absolute line level.
- R2: A transition interval of L samples is a half-cell if OVS/2 <= L < 3*OVS/2, a full bit if 3*OVS/2 <= L < 3*OVS, a sync run if 3*OVS <= L < 5*OVS, and illegal otherwise. A full-bit interval decodes as 0 and two half-cell intervals decode as 1, so half-cells of OVS-1 and OVS+1 samples still decode correctly.
- R3: Two consecutive sync runs mark a frame start. The following 508 decoded bits are frame bits 4..511, and every complete frame produces exactly one output frame.
- R4: `o_carrier[31]` is frame bit 4 and `o_carrier[0]` is bit 35. `o_cblk` is bit 36, `o_act[n]` is bit 39+n, and `o_zblk[p]` is bit 55+p.
- R5: Channel slot n (0..15) occupies frame bits 64+28n..91+28n. The first received bit of a slot appears in bit 0 of `o_words[28n +: 28]`.
- R6: When `o_act[n]` is 0, the word for channel n is presented as all zeros, whatever data the slot carried.
- R7: `o_cp_err` is 1 exactly when frame bits 4..37 hold an odd number of ones.
- R8: `o_hp_err` is 1 exactly when frame bits 38 and 55..63 hold an odd number of ones.
- R9: `o_phase` (frame bit 38) is presented in the same output beat as the channel words of its frame.
- R10: While `o_valid` is 1 and `o_ready` is 0, all outputs of the frame hold still. A frame completing in that state is dropped.
- R11: `locked` rises only when a sync pattern is detected 1024*OVS samples (within OVS/2) after the previous one. It is 0 after reset.
- R12: Once locked, `locked` falls after two consecutive frame periods pass without a sync pattern in the expected window.
- R13: `code_err` pulses for an illegal interval or for a full-bit interval that follows a lone half-cell. It stays 0 on a clean stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, OVS per half-cell |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Biphase-mark line sample, either polarity |
| o_valid | output | 1 | A decoded frame is offered |
| o_ready | input | 1 | Consumer takes the offered frame |
| o_words | output | 448 | Sixteen 28-bit channel words, channel n at [28n +: 28] |
| o_act | output | 16 | Active flag per channel |
| o_zblk | output | 8 | Block-start flag per channel pair |
| o_phase | output | 1 | Multichannel phasing flag |
| o_carrier | output | 32 | Carrier data, first received bit in MSB |
| o_cblk | output | 1 | Carrier block start bit |
| o_cp_err | output | 1 | Carrier parity span odd |
| o_hp_err | output | 1 | Flag parity span odd |
| locked | output | 1 | Frame lock indicator |
| code_err | output | 1 | One-cycle pulse on a coding violation |

## Verification
The assertions check, on every cycle, that a waiting frame holds still under back-pressure and that a new frame appears only after a completed one. They also check that an inactive channel never shows a nonzero word and that lock only rises on a detected sync. Field placement, both parity checks, tolerance of half-cell timing skew, polarity independence, dropping a frame under back-pressure and the loss of lock over an idle line can be shown only by the bench. It does this by sending constructed frames and comparing every delivered frame with the fields it encoded.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int FRAME_BITS = 512;
  localparam int SYNC_BITS  = 4;
  localparam int HDR_BITS   = 64;
  localparam int SLOT_BITS  = 28;
  localparam int N_SLOTS    = 16;
  localparam int N_PAIRS    = 8;
  localparam int CAR_BITS   = 32;
  localparam int PAY_BITS   = FRAME_BITS - SYNC_BITS;
  localparam int WORDS_W    = SLOT_BITS * N_SLOTS;

  typedef enum logic [1:0] {
    IV_SHORT = 2'd0,
    IV_LONG  = 2'd1,
    IV_SYNC  = 2'd2,
    IV_BAD   = 2'd3
  } iv_cls_t;
endpackage

// File: rtl/bmc_interval.sv
module bmc_interval import bmc_pkg::*; #(
  parameter int OVS = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    line_in,
  output logic    ev_vld,
  output iv_cls_t ev_cls
);
  localparam int T_MIN = OVS / 2;
  localparam int T_SL  = (3 * OVS) / 2;
  localparam int T_LS  = 3 * OVS;
  localparam int T_MAX = 5 * OVS;
  localparam int CW    = $clog2(T_MAX + 1) + 1;

  logic          s1, s2, s3;
  logic [CW-1:0] run;
  logic          edge_seen;
  iv_cls_t       cls_now;

  assign edge_seen = s2 ^ s3;

  always_comb begin
    if (run < CW'(T_MIN))      cls_now = IV_BAD;
    else if (run < CW'(T_SL))  cls_now = IV_SHORT;
    else if (run < CW'(T_LS))  cls_now = IV_LONG;
    else if (run < CW'(T_MAX)) cls_now = IV_SYNC;
    else                       cls_now = IV_BAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      run <= CW'(T_MAX);
      ev_vld <= 1'b0;
      ev_cls <= IV_BAD;
    end else begin
      s1 <= line_in;
      s2 <= s1;
      s3 <= s2;
      ev_vld <= edge_seen;
      if (edge_seen) begin
        ev_cls <= cls_now;
        run    <= CW'(1);
      end else if (run < CW'(T_MAX)) begin
        run <= run + CW'(1);
      end
    end
  end
endmodule

// File: rtl/bmc_bitdec.sv
module bmc_bitdec import bmc_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_vld,
  input  iv_cls_t             ev_cls,
  output logic [PAY_BITS-1:0] pay,
  output logic                frame_done,
  output logic                sync_pulse,
  output logic                code_err
);
  localparam int IW = $clog2(FRAME_BITS) + 1;

  logic          half_pend, sync_half, framed;
  logic [IW-1:0] idx;
  logic          emit, ebit, err;

  always_comb begin
    emit = 1'b0; ebit = 1'b0; err = 1'b0;
    if (ev_vld) begin
      case (ev_cls)
        IV_SHORT: if (half_pend) begin emit = 1'b1; ebit = 1'b1; end
        IV_LONG:  if (half_pend) err = 1'b1; else emit = 1'b1;
        IV_BAD:   err = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_pend <= 1'b0; sync_half <= 1'b0; framed <= 1'b0;
      idx <= '0; pay <= '0;
      frame_done <= 1'b0; sync_pulse <= 1'b0; code_err <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      sync_pulse <= 1'b0;
      code_err   <= err;
      if (ev_vld) begin
        case (ev_cls)
          IV_SHORT: begin half_pend <= !half_pend; sync_half <= 1'b0; end
          IV_SYNC:  begin
            half_pend <= 1'b0;
            if (sync_half) begin
              sync_half  <= 1'b0;
              framed     <= 1'b1;
              idx        <= IW'(SYNC_BITS);
              sync_pulse <= 1'b1;
            end else begin
              sync_half <= 1'b1;
            end
          end
          default:  begin half_pend <= 1'b0; sync_half <= 1'b0; end
        endcase
      end
      if (emit && framed) begin
        pay <= {pay[PAY_BITS-2:0], ebit};
        idx <= idx + IW'(1);
        if (idx == IW'(FRAME_BITS - 1)) begin
          framed     <= 1'b0;
          frame_done <= 1'b1;
        end
      end
      if (err) framed <= 1'b0;
    end
  end
endmodule

// File: rtl/bmc_unpack.sv
module bmc_unpack import bmc_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PAY_BITS-1:0] pay,
  input  logic                frame_done,
  output logic                o_valid,
  input  logic                o_ready,
  output logic [WORDS_W-1:0]  o_words,
  output logic [N_SLOTS-1:0]  o_act,
  output logic [N_PAIRS-1:0]  o_zblk,
  output logic                o_phase,
  output logic [CAR_BITS-1:0] o_carrier,
  output logic                o_cblk,
  output logic                o_cp_err,
  output logic                o_hp_err
);
  // frame bit k sits at pay[FRAME_BITS-1-k]
  localparam int P_CAR = FRAME_BITS - 1 - SYNC_BITS;
  localparam int P_CB  = P_CAR - CAR_BITS;
  localparam int P_CP  = P_CB - 1;
  localparam int P_MC  = P_CP - 1;
  localparam int P_ACT = P_MC - 1;
  localparam int P_Z   = P_ACT - N_SLOTS;
  localparam int P_HP  = P_Z - N_PAIRS;
  localparam int P_W0  = FRAME_BITS - 1 - HDR_BITS;

  logic [WORDS_W-1:0]  n_words;
  logic [N_SLOTS-1:0]  n_act;
  logic [N_PAIRS-1:0]  n_z;
  logic                n_cp_err, n_hp_err, load;

  always_comb begin
    for (int n = 0; n < N_SLOTS; n++) n_act[n] = pay[P_ACT - n];
    for (int p = 0; p < N_PAIRS; p++) n_z[p] = pay[P_Z - p];
    n_cp_err = ^pay[P_CAR -: (CAR_BITS + 2)];
    n_hp_err = pay[P_MC] ^ (^n_z) ^ pay[P_HP];
  end

  for (genvar n = 0; n < N_SLOTS; n++) begin : g_slot
    for (genvar b = 0; b < SLOT_BITS; b++) begin : g_bit
      assign n_words[n*SLOT_BITS + b] = n_act[n] & pay[P_W0 - n*SLOT_BITS - b];
    end
  end

  assign load = frame_done && (!o_valid || o_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_words <= '0; o_act <= '0; o_zblk <= '0; o_phase <= 1'b0;
      o_carrier <= '0; o_cblk <= 1'b0; o_cp_err <= 1'b0; o_hp_err <= 1'b0;
    end else begin
      if (load) begin
        o_valid   <= 1'b1;
        o_words   <= n_words;
        o_act     <= n_act;
        o_zblk    <= n_z;
        o_phase   <= pay[P_MC];
        o_carrier <= pay[P_CAR -: CAR_BITS];
        o_cblk    <= pay[P_CB];
        o_cp_err  <= n_cp_err;
        o_hp_err  <= n_hp_err;
      end else if (o_ready) begin
        o_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bmc_lock.sv
module bmc_lock import bmc_pkg::*; #(
  parameter int OVS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_pulse,
  output logic locked
);
  localparam int FS   = 2 * OVS * FRAME_BITS;
  localparam int TOL  = OVS / 2;
  localparam int WLO  = FS - 1 - TOL;
  localparam int WHI  = FS - 1 + TOL;
  localparam int DEAD = WHI + 1;
  localparam int CW   = $clog2(DEAD + 2);

  logic [CW-1:0] since;
  logic          have_ref, miss1, in_win;

  assign in_win = (since >= CW'(WLO)) && (since <= CW'(WHI));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since <= '0; have_ref <= 1'b0; miss1 <= 1'b0; locked <= 1'b0;
    end else if (sync_pulse) begin
      since    <= '0;
      have_ref <= 1'b1;
      if (have_ref && in_win) begin
        locked <= 1'b1;
        miss1  <= 1'b0;
      end else if (locked) begin
        if (miss1) begin locked <= 1'b0; miss1 <= 1'b0; end
        else miss1 <= 1'b1;
      end
    end else if (have_ref && since == CW'(DEAD)) begin
      since <= CW'(TOL);
      if (!locked) begin
        have_ref <= 1'b0;
      end else if (miss1) begin
        locked <= 1'b0; miss1 <= 1'b0; have_ref <= 1'b0;
      end else begin
        miss1 <= 1'b1;
      end
    end else if (have_ref) begin
      since <= since + CW'(1);
    end
  end
endmodule

// File: rtl/bmc_frame_rx.sv
module bmc_frame_rx import bmc_pkg::*; #(
  parameter int OVS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_line,
  output logic                o_valid,
  input  logic                o_ready,
  output logic [WORDS_W-1:0]  o_words,
  output logic [N_SLOTS-1:0]  o_act,
  output logic [N_PAIRS-1:0]  o_zblk,
  output logic                o_phase,
  output logic [CAR_BITS-1:0] o_carrier,
  output logic                o_cblk,
  output logic                o_cp_err,
  output logic                o_hp_err,
  output logic                locked,
  output logic                code_err
);
  logic                ev_vld;
  iv_cls_t             ev_cls;
  logic [PAY_BITS-1:0] pay;
  logic                w_done, w_sync;

  bmc_interval #(.OVS(OVS)) u_iv (
    .clk(clk), .rst_n(rst_n), .line_in(rx_line), .ev_vld(ev_vld), .ev_cls(ev_cls));

  bmc_bitdec u_dec (
    .clk(clk), .rst_n(rst_n), .ev_vld(ev_vld), .ev_cls(ev_cls), .pay(pay),
    .frame_done(w_done), .sync_pulse(w_sync), .code_err(code_err));

  bmc_unpack u_unp (
    .clk(clk), .rst_n(rst_n), .pay(pay), .frame_done(w_done),
    .o_valid(o_valid), .o_ready(o_ready), .o_words(o_words), .o_act(o_act),
    .o_zblk(o_zblk), .o_phase(o_phase), .o_carrier(o_carrier), .o_cblk(o_cblk),
    .o_cp_err(o_cp_err), .o_hp_err(o_hp_err));

  bmc_lock #(.OVS(OVS)) u_lock (
    .clk(clk), .rst_n(rst_n), .sync_pulse(w_sync), .locked(locked));
endmodule

// File: rtl/bmc_frame_rx_chk.sv
module bmc_frame_rx_chk import bmc_pkg::*; (
  input logic               clk,
  input logic               rst_n,
  input logic               o_valid,
  input logic               o_ready,
  input logic [WORDS_W-1:0] o_words,
  input logic [N_SLOTS-1:0] o_act,
  input logic [CAR_BITS-1:0] o_carrier,
  input logic               o_phase,
  input logic               locked,
  input logic               frame_done,
  input logic               sync_pulse
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_words) && $stable(o_carrier) && $stable(o_phase)));

  assert_new_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_valid) |-> $past(frame_done));

  assert_lock_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(sync_pulse));

  for (genvar n = 0; n < N_SLOTS; n++) begin : g_mute
    assert_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (o_valid && !o_act[n]) |-> (o_words[n*SLOT_BITS +: SLOT_BITS] == '0));
  end
endmodule

bind bmc_frame_rx bmc_frame_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .o_valid(o_valid), .o_ready(o_ready),
  .o_words(o_words), .o_act(o_act), .o_carrier(o_carrier), .o_phase(o_phase),
  .locked(locked), .frame_done(w_done), .sync_pulse(w_sync));

// File: tb/test_bmc_frame_rx.sv
module test_bmc_frame_rx;
  import bmc_pkg::*;
  localparam int OVS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b0;
  logic o_ready = 1'b0;
  logic o_valid, o_phase, o_cblk, o_cp_err, o_hp_err, locked, code_err;
  logic [WORDS_W-1:0]  o_words;
  logic [N_SLOTS-1:0]  o_act;
  logic [N_PAIRS-1:0]  o_zblk;
  logic [CAR_BITS-1:0] o_carrier;

  always #2.5 clk = ~clk;

  bmc_frame_rx #(.OVS(OVS)) i_bmc_frame_rx (.*);

  typedef struct packed {
    logic [WORDS_W-1:0]  w;
    logic [N_SLOTS-1:0]  act;
    logic [N_PAIRS-1:0]  z;
    logic                mc;
    logic [CAR_BITS-1:0] car;
    logic                cb;
    logic                cpe;
    logic                hpe;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, popped = 0, err_pulses = 0;
  logic hold = 1'b0, lvl = 1'b0, inv = 1'b0, finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int n);
    repeat (n) begin @(negedge clk); rx_line = lvl ^ inv; end
  endtask

  task automatic tail();
    lvl = ~lvl; put(2 * OVS);
  endtask

  function automatic logic [WORDS_W-1:0] mkw(input int seed);
    logic [WORDS_W-1:0] w;
    for (int n = 0; n < N_SLOTS; n++)
      w[n*SLOT_BITS +: SLOT_BITS] = 28'(32'h9E3779B * (seed + 1) + 32'h0123457 * n);
    return w;
  endfunction

  // driver: encodes one frame and queues the expected result
  task automatic send(input logic [31:0] car, input logic cb, input logic mc,
                      input logic [15:0] act, input logic [7:0] z, input int seed,
                      input logic bad_cp, input logic bad_hp, input logic push, input logic jit);
    logic [FRAME_BITS-1:0] fb;
    logic [WORDS_W-1:0] w;
    exp_t e;
    w = mkw(seed);
    fb = '0;
    for (int i = 0; i < 32; i++) fb[4+i] = car[31-i];
    fb[36] = cb;
    fb[37] = (^car) ^ cb ^ bad_cp;
    fb[38] = mc;
    for (int n = 0; n < 16; n++) fb[39+n] = act[n];
    for (int p = 0; p < 8; p++) fb[55+p] = z[p];
    fb[63] = mc ^ (^z) ^ bad_hp;
    for (int n = 0; n < 16; n++)
      for (int b = 0; b < 28; b++) fb[64 + 28*n + b] = w[28*n + b];
    e.w = w;
    for (int n = 0; n < 16; n++) if (!act[n]) e.w[28*n +: 28] = '0;
    e.act = act; e.z = z; e.mc = mc; e.car = car; e.cb = cb;
    e.cpe = bad_cp; e.hpe = bad_hp;
    lvl = ~lvl; put(4 * OVS);
    lvl = ~lvl; put(4 * OVS);
    for (int k = 4; k < FRAME_BITS; k++) begin
      lvl = ~lvl;
      if (fb[k]) begin
        put(jit ? OVS + 1 : OVS);
        lvl = ~lvl;
        put(jit ? OVS - 1 : OVS);
      end else begin
        put(2 * OVS);
      end
    end
    if (push) q.push_back(e);
  endtask

  // monitor: owns o_ready, compares each accepted frame
  initial begin
    forever begin
      @(negedge clk);
      if (code_err) err_pulses++;
      o_ready = !hold;
      if (rst_n && o_valid && o_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R3 unexpected frame", 64'(o_carrier), 64'h0);
        end else begin
          exp_t e;
          e = q.pop_front();
          popped++;
          chk(o_words == e.w, "R5 words", 64'(o_words), 64'(e.w));
          chk(o_act == e.act, "R6 act", 64'(o_act), 64'(e.act));
          chk(o_carrier == e.car && o_cblk == e.cb && o_zblk == e.z, "R4 fields",
              {31'(0), o_cblk, o_carrier}, {31'(0), e.cb, e.car});
          chk(o_phase == e.mc, "R9 phase", 64'(o_phase), 64'(e.mc));
          chk(o_cp_err == e.cpe, "R7 cp", 64'(o_cp_err), 64'(e.cpe));
          chk(o_hp_err == e.hpe, "R8 hp", 64'(o_hp_err), 64'(e.hpe));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(o_valid == 1'b0, "R10 reset valid", 64'(o_valid), 64'h0);
    chk(locked == 1'b0, "R11 reset lock", 64'(locked), 64'h0);
    put(40);

    send(32'hA5C3_0F81, 1'b1, 1'b1, 16'hFFFF, 8'h01, 1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(locked == 1'b0, "R11 one sync", 64'(locked), 64'h0);
    err_pulses = 0;
    send(32'h1234_5678, 1'b0, 1'b0, 16'hFFFF, 8'h80, 2, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(locked == 1'b1, "R11 two syncs", 64'(locked), 64'h1);
    send(32'hFFFF_0000, 1'b1, 1'b0, 16'h00FF, 8'h5A, 3, 1'b0, 1'b0, 1'b1, 1'b1); // R2 skewed half-cells
    send(32'h0000_0001, 1'b0, 1'b1, 16'hF0F0, 8'h00, 4, 1'b1, 1'b0, 1'b1, 1'b0); // R7
    send(32'h8000_0000, 1'b0, 1'b0, 16'h3C3C, 8'hFF, 5, 1'b0, 1'b1, 1'b1, 1'b0); // R8 R6
    send(32'hDEAD_BEEF, 1'b1, 1'b1, 16'h0000, 8'h81, 6, 1'b1, 1'b1, 1'b1, 1'b0);
    tail();
    put(100);
    chk(err_pulses == 0, "R13 clean stream", 64'(err_pulses), 64'h0);
    chk(q.size() == 0 && popped == 6, "R3 frame count", 64'(popped), 64'h6);

    put(2000);
    chk(locked == 1'b1, "R12 one miss", 64'(locked), 64'h1);
    put(4000);
    chk(locked == 1'b0, "R12 two misses", 64'(locked), 64'h0);

    err_pulses = 0;
    lvl = ~lvl; put(1); lvl = ~lvl; put(40);
    chk(err_pulses >= 1, "R13 glitch", 64'(err_pulses), 64'h1);

    hold = 1'b1;
    send(32'hCAFE_F00D, 1'b0, 1'b1, 16'hAAAA, 8'h24, 7, 1'b0, 1'b0, 1'b1, 1'b0);
    send(32'h0BAD_0BAD, 1'b1, 1'b0, 16'h5555, 8'h42, 8, 1'b0, 1'b0, 1'b0, 1'b0);
    tail();
    put(50);
    chk(o_valid == 1'b1, "R10 held valid", 64'(o_valid), 64'h1);
    chk(o_carrier == 32'hCAFE_F00D, "R10 held data", 64'(o_carrier), 64'hCAFE_F00D);
    hold = 1'b0;
    put(20);
    chk(q.size() == 0 && popped == 7 && o_valid == 1'b0, "R10 drop", 64'(popped), 64'h7);

    inv = 1'b1;
    put(50);
    send(32'h1357_9BDF, 1'b1, 1'b0, 16'hFFFF, 8'h10, 9, 1'b0, 1'b0, 1'b1, 1'b0);
    send(32'h2468_ACE0, 1'b0, 1'b1, 16'h0FF0, 8'h08, 10, 1'b1, 1'b0, 1'b1, 1'b0);
    tail();
    put(50);
    chk(q.size() == 0 && popped == 9, "R1 inverted line", 64'(popped), 64'h9);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule